// File: doc/BRIEF.md
# General-Purpose Port Data Register

This block holds the output data for a 16-pin general-purpose port and returns a per-pin read value on a simple memory-mapped bus. Each pin has a direction input (1 = output) and an alternate-function input that come from logic outside the block. When a pin is a plain output, the pin takes the stored bit. In every other case a write still updates the stored bit but the pin stays undriven. A read returns the stored bit for output pins, with or without the alternate function. For input pins it returns the synchronized pin level.

The bus has a single request strobe with a write qualifier, a size field, a 28-bit byte address and a 32-bit data path. The response comes one cycle later. The decoder compares only the top four and the bottom nine address bits, so the register appears at many aliases. Only power-on reset clears the stored data. Manual reset clears just the read-response stage and the input synchronizer. Standby and sleep freeze the synchronizer and leave the data alone.

Top module: `gpio_port_data`

## Requirements
- R1: Power-on reset (`por_n` low, asynchronous) clears the stored value to 0x0000; while it is low `pin_out` is 0 and `bus_rvalid` is 0.
- R2: For a pin with direction 1 and alternate-function 0, `pin_oe` is 1 and `pin_out` equals the stored bit.
- R3: For a pin with direction 0, a read returns the pin level through a two-stage synchronizer, whatever the alternate-function bit is. A pin change driven just before clock edge E is seen by a read request sampled at edge E+2, but not by one sampled at E or E+1.
- R4: For a pin with direction 1 and alternate-function 1, a read returns the stored bit.
- R5: A write to a hit address updates the stored bits in every pin mode. For pins that are not plain outputs, `pin_oe` and `pin_out` are 0, and a stored value appears on the pin once the pin becomes a plain output.
- R6: Manual reset (`mrst_n` low), `standby` and `sleep` leave the stored value unchanged.
- R7: A hit requires `bus_addr[27:24]` = 0x5. For halfword and word accesses it also requires `bus_addr[8:0]` = 0x1C0, and for byte accesses `bus_addr[8:1]` = 0xE0. Bits 23:9 are ignored. A size code of 3 never hits. A write that misses changes nothing, and a read that misses returns zero.
- R8: Size code 0 is a byte access. Address bit 0 = 0 selects stored bits 15:8 and bit 0 = 1 selects bits 7:0. The byte travels on data bits 7:0, bits 31:8 read as zero, and the other stored byte is unchanged.
- R9: Size code 1 is a halfword access to all 16 stored bits on data bits 15:0. Bits 31:16 read as zero.
- R10: Size code 2 is a word access. The register sits on data bits 31:16, data bits 15:0 are ignored on write and read as zero.
- R11: Every read request is answered by `bus_rvalid` high in the next cycle, with `bus_rdata` valid in that cycle. A write request gives no `bus_rvalid`, and `bus_rdata` is zero whenever `bus_rvalid` is low.
- R12: While `standby` or `sleep` is high, the input synchronizer holds its contents, so input-pin reads return the level captured before entry. Sampling resumes when both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, synchronous |
| standby | input | 1 | Standby mode indication |
| sleep | input | 1 | Sleep mode indication |
| bus_req | input | 1 | Access request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr | input | 28 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| pin_dir | input | 16 | Per-pin direction, 1 = output |
| pin_alt | input | 16 | Per-pin alternate function selected |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Pin drive value |
| pin_oe | output | 16 | Pin drive enable |

## Verification
The bench targets the byte-lane corner: a design with the lanes swapped would return and update the wrong half on odd and even byte addresses. It probes the alias and miss decodes, including a halfword at an odd address and the reserved size, which a loose decoder would accept. It counts synchronizer latency one edge at a time, so a design with one stage too few or too many shows the new pin level a cycle early or late. It also checks that manual reset and the low-power inputs keep the stored data, where a design sharing one reset would read back zero. It mixes directed cases with random pin modes, sizes and aliased addresses.

// File: rtl/gpio_pd_pkg.sv
package gpio_pd_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic      rd;
        logic      wr;
        logic      hit;
        acc_size_e size;
    } dec_info_t;

endpackage

// File: rtl/gpio_pd_decode.sv
module gpio_pd_decode
    import gpio_pd_pkg::*;
#(
    parameter int                ADDR_W    = 28,
    parameter int                NBYTES    = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 28'h5FFFFC0,
    parameter logic [ADDR_W-1:0] DEC_MASK  = 28'hF0001FF,
    localparam int               OFF_W     = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output dec_info_t         info,
    output logic [NBYTES-1:0] byte_en,
    output logic [OFF_W-1:0]  byte_idx
);

    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(NBYTES - 1);
    localparam logic [ADDR_W-1:0] REF_FULL = BASE_ADDR & DEC_MASK;
    localparam logic [ADDR_W-1:0] REF_LANE = REF_FULL & ~OFF_MASK;

    logic full_hit;
    logic lane_hit;
    logic hit;

    always_comb begin
        full_hit = (addr & DEC_MASK) == REF_FULL;
        lane_hit = (addr & DEC_MASK & ~OFF_MASK) == REF_LANE;
        byte_idx = addr[OFF_W-1:0];
        byte_en  = '0;
        hit      = 1'b0;
        case (acc_size_e'(size))
            SZ_BYTE: begin
                hit = lane_hit;
                for (int b = 0; b < NBYTES; b++) begin
                    byte_en[b] = (int'(byte_idx) == NBYTES - 1 - b);
                end
            end
            SZ_HALF, SZ_WORD: begin
                hit     = full_hit;
                byte_en = '1;
            end
            default: begin
                hit     = 1'b0;
                byte_en = '0;
            end
        endcase
        info.rd   = req & ~we;
        info.wr   = req & we & hit;
        info.hit  = hit;
        info.size = acc_size_e'(size);
    end

endmodule

// File: rtl/gpio_pd_sync.sv
module gpio_pd_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         mrst_n,
    input  logic         hold,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_sync
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t st_d;
    sync_t st_q;

    always_comb begin
        st_d = st_q;
        if (!mrst_n) begin
            st_d.chain = '0;
        end else if (!hold) begin
            st_d.chain[0] = pin_in;
            for (int s = 1; s < STAGES; s++) begin
                st_d.chain[s] = st_q.chain[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_sync = st_q.chain[STAGES-1];

endmodule

// File: rtl/gpio_pd_store.sv
module gpio_pd_store
    import gpio_pd_pkg::*;
#(
    parameter int  PORT_W = 16,
    parameter int  BUS_W  = 32,
    localparam int NBYTES = PORT_W / 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr,
    input  acc_size_e         size,
    input  logic [NBYTES-1:0] byte_en,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [PORT_W-1:0] pin_dir,
    input  logic [PORT_W-1:0] pin_alt,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);

    typedef struct packed {
        logic [PORT_W-1:0] data;
    } store_t;

    store_t            st_d;
    store_t            st_q;
    logic [PORT_W-1:0] lane_data;
    logic [PORT_W-1:0] lane_next;

    always_comb begin
        case (size)
            SZ_BYTE: lane_data = {NBYTES{wdata[7:0]}};
            SZ_HALF: lane_data = wdata[PORT_W-1:0];
            SZ_WORD: lane_data = wdata[BUS_W-1 -: PORT_W];
            default: lane_data = '0;
        endcase
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign lane_next[b*8 +: 8] = (wr && byte_en[b]) ? lane_data[b*8 +: 8]
                                                       : st_q.data[b*8 +: 8];
    end

    always_comb begin
        st_d      = st_q;
        st_d.data = lane_next;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_q  = st_q.data;
    assign pin_oe  = pin_dir & ~pin_alt;
    assign pin_out = st_q.data & pin_oe;

endmodule

// File: rtl/gpio_pd_rdpath.sv
module gpio_pd_rdpath
    import gpio_pd_pkg::*;
#(
    parameter int  PORT_W = 16,
    parameter int  BUS_W  = 32,
    localparam int NBYTES = PORT_W / 8,
    localparam int OFF_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              rd,
    input  logic              hit,
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  byte_idx,
    input  logic [PORT_W-1:0] data_q,
    input  logic [PORT_W-1:0] pin_sync,
    input  logic [PORT_W-1:0] pin_dir,
    output logic              rvalid,
    output logic [BUS_W-1:0]  rdata
);

    typedef struct packed {
        logic             rvalid;
        logic [BUS_W-1:0] rdata;
    } resp_t;

    resp_t             rs_d;
    resp_t             rs_q;
    logic [PORT_W-1:0] view;
    logic [7:0]        byte_sel;
    logic [BUS_W-1:0]  fmt;

    always_comb begin
        view     = (pin_dir & data_q) | (~pin_dir & pin_sync);
        byte_sel = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (int'(byte_idx) == NBYTES - 1 - b) begin
                byte_sel = view[b*8 +: 8];
            end
        end
        case (size)
            SZ_BYTE: fmt = BUS_W'(byte_sel);
            SZ_HALF: fmt = BUS_W'(view);
            SZ_WORD: fmt = {view, {(BUS_W-PORT_W){1'b0}}};
            default: fmt = '0;
        endcase
    end

    always_comb begin
        rs_d        = rs_q;
        rs_d.rvalid = rd & mrst_n;
        rs_d.rdata  = (rd && hit && mrst_n) ? fmt : '0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rvalid = rs_q.rvalid;
    assign rdata  = rs_q.rdata;

endmodule

// File: rtl/gpio_port_data.sv
module gpio_port_data
    import gpio_pd_pkg::*;
#(
    parameter int                ADDR_W      = 28,
    parameter int                BUS_W       = 32,
    parameter int                PORT_W      = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 28'h5FFFFC0,
    parameter logic [ADDR_W-1:0] DEC_MASK    = 28'hF0001FF
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              standby,
    input  logic              sleep,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic [PORT_W-1:0] pin_dir,
    input  logic [PORT_W-1:0] pin_alt,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);

    localparam int NBYTES = PORT_W / 8;
    localparam int OFF_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    dec_info_t         info;
    logic [NBYTES-1:0] byte_en;
    logic [OFF_W-1:0]  byte_idx;
    logic [PORT_W-1:0] port_data;
    logic [PORT_W-1:0] pin_sync;
    logic              lp_hold;

    assign lp_hold = standby | sleep;

    gpio_pd_decode #(
        .ADDR_W   (ADDR_W),
        .NBYTES   (NBYTES),
        .BASE_ADDR(BASE_ADDR),
        .DEC_MASK (DEC_MASK)
    ) i_decode (
        .req     (bus_req),
        .we      (bus_we),
        .size    (bus_size),
        .addr    (bus_addr),
        .info    (info),
        .byte_en (byte_en),
        .byte_idx(byte_idx)
    );

    gpio_pd_sync #(
        .W     (PORT_W),
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .por_n   (por_n),
        .mrst_n  (mrst_n),
        .hold    (lp_hold),
        .pin_in  (pin_in),
        .pin_sync(pin_sync)
    );

    gpio_pd_store #(
        .PORT_W(PORT_W),
        .BUS_W (BUS_W)
    ) i_store (
        .clk    (clk),
        .por_n  (por_n),
        .wr     (info.wr),
        .size   (info.size),
        .byte_en(byte_en),
        .wdata  (bus_wdata),
        .pin_dir(pin_dir),
        .pin_alt(pin_alt),
        .data_q (port_data),
        .pin_out(pin_out),
        .pin_oe (pin_oe)
    );

    gpio_pd_rdpath #(
        .PORT_W(PORT_W),
        .BUS_W (BUS_W)
    ) i_rdpath (
        .clk     (clk),
        .por_n   (por_n),
        .mrst_n  (mrst_n),
        .rd      (info.rd),
        .hit     (info.hit),
        .size    (info.size),
        .byte_idx(byte_idx),
        .data_q  (port_data),
        .pin_sync(pin_sync),
        .pin_dir (pin_dir),
        .rvalid  (bus_rvalid),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/gpio_port_data_chk.sv
module gpio_port_data_chk #(
    parameter int                ADDR_W    = 28,
    parameter int                BUS_W     = 32,
    parameter int                PORT_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 28'h5FFFFC0
) (
    input logic              clk,
    input logic              por_n,
    input logic              mrst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              bus_rvalid,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] pin_oe,
    input logic [PORT_W-1:0] port_data
);

    always @(posedge clk) begin
        if (!por_n) begin
            assert_por_clear_R1: assert (port_data == '0 && pin_out == '0 && !bus_rvalid)
                else $error("R1 power-on reset did not clear state");
        end
    end

    assert_plain_drive_R2: assert property (@(posedge clk) disable iff (!por_n)
        ((pin_oe & (pin_out ^ port_data)) == '0));

    assert_no_stray_drive_R5: assert property (@(posedge clk) disable iff (!por_n)
        ((pin_out & ~pin_oe) == '0));

    assert_store_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
        !(bus_req && bus_we) |=> $stable(port_data));

    assert_region_miss_R7: assert property (@(posedge clk) disable iff (!por_n)
        (bus_req && bus_we && bus_addr[ADDR_W-1 -: 4] != BASE_ADDR[ADDR_W-1 -: 4])
        |=> $stable(port_data));

    assert_word_low_zero_R10: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rvalid && $past(bus_size) == 2'd2) |-> (bus_rdata[BUS_W-PORT_W-1:0] == '0));

    assert_read_answered_R11: assert property (@(posedge clk) disable iff (!por_n)
        (bus_req && !bus_we && mrst_n) |=> bus_rvalid);

    assert_write_silent_R11: assert property (@(posedge clk) disable iff (!por_n)
        (bus_req && bus_we) |=> !bus_rvalid);

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!por_n)
        !bus_rvalid |-> (bus_rdata == '0));

endmodule

bind gpio_port_data gpio_port_data_chk #(
    .ADDR_W   (ADDR_W),
    .BUS_W    (BUS_W),
    .PORT_W   (PORT_W),
    .BASE_ADDR(BASE_ADDR)
) i_chk (
    .clk       (clk),
    .por_n     (por_n),
    .mrst_n    (mrst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .port_data (port_data)
);

// File: tb/test_gpio_port_data.sv
module test_gpio_port_data;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        mrst_n = 1'b1;
    logic        standby = 1'b0;
    logic        sleep = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [27:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [15:0] pin_dir = '0;
    logic [15:0] pin_alt = '0;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [15:0] exp_store = '0;

    localparam logic [27:0] BASE = 28'h5FFFFC0;

    always #10 clk = ~clk;

    gpio_port_data i_gpio_port_data (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .standby(standby), .sleep(sleep),
        .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .pin_dir(pin_dir), .pin_alt(pin_alt), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit fn_hit(input logic [27:0] a, input logic [1:0] sz);
        if (a[27:24] != 4'h5) return 1'b0;
        if (sz == 2'd0) return a[8:1] == 8'hE0;
        if (sz == 2'd1 || sz == 2'd2) return a[8:0] == 9'h1C0;
        return 1'b0;
    endfunction

    function automatic logic [15:0] fn_write(input logic [15:0] cur, input logic [27:0] a,
                                             input logic [1:0] sz, input logic [31:0] d);
        logic [15:0] r = cur;
        if (!fn_hit(a, sz)) return cur;
        case (sz)
            2'd0: if (a[0]) r[7:0] = d[7:0]; else r[15:8] = d[7:0];
            2'd1: r = d[15:0];
            default: r = d[31:16];
        endcase
        return r;
    endfunction

    function automatic logic [31:0] fn_read(input logic [15:0] st, input logic [15:0] pins,
                                            input logic [15:0] dir, input logic [27:0] a,
                                            input logic [1:0] sz);
        logic [15:0] v = (st & dir) | (pins & ~dir);
        if (!fn_hit(a, sz)) return 32'h0;
        case (sz)
            2'd0: return a[0] ? {24'h0, v[7:0]} : {24'h0, v[15:8]};
            2'd1: return {16'h0, v};
            default: return {v, 16'h0};
        endcase
    endfunction

    task automatic do_write(input logic [27:0] a, input logic [1:0] sz, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        exp_store = fn_write(exp_store, a, sz, d);
        chk("R11 no rvalid after write", {31'h0, bus_rvalid}, 32'h0);
    endtask

    task automatic do_read(input logic [27:0] a, input logic [1:0] sz,
                           output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
        chk("R11 rvalid after read", {31'h0, bus_rvalid}, 32'h1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        pin_dir = 16'hFFFF; pin_alt = 16'h0000; pin_in = 16'hAAAA;
        idle(3);
        chk("R1 pin_out in reset", {16'h0, pin_out}, 32'h0);
        chk("R1 rvalid in reset", {31'h0, bus_rvalid}, 32'h0);
        por_n = 1'b1;
        idle(3);
        chk("R2 oe on plain outputs", {16'h0, pin_oe}, 32'h0000FFFF);
        do_read(BASE, 2'd1, rd);
        chk("R1 reset value", rd, 32'h0);

        do_write(BASE, 2'd1, 32'hDEAD1234);
        chk("R2 pin drives stored", {16'h0, pin_out}, 32'h1234);
        do_read(BASE, 2'd1, rd);
        chk("R9 halfword read", rd, 32'h00001234);

        do_write(BASE, 2'd0, 32'h000000AB);
        do_read(BASE, 2'd1, rd);
        chk("R8 even byte hits upper", rd, 32'h0000AB34);
        do_write(BASE | 28'h1, 2'd0, 32'hFFFFFFCD);
        do_read(BASE, 2'd1, rd);
        chk("R8 odd byte hits lower", rd, 32'h0000ABCD);
        do_read(BASE, 2'd0, rd);
        chk("R8 even byte read", rd, 32'h000000AB);
        do_read(BASE | 28'h1, 2'd0, rd);
        chk("R8 odd byte read", rd, 32'h000000CD);

        do_write(BASE, 2'd2, 32'h5678FFFF);
        do_read(BASE, 2'd2, rd);
        chk("R10 word read upper", rd, 32'h56780000);

        do_write(28'h5ABC1C0, 2'd1, 32'h00002222);
        do_read(28'h5000FC0, 2'd1, rd);
        chk("R7 alias hit", rd, 32'h00002222);
        do_write(28'h6FFFFC0, 2'd1, 32'h00003333);
        do_write(BASE | 28'h1, 2'd1, 32'h00004444);
        do_write(BASE, 2'd3, 32'h55555555);
        do_write(BASE ^ 28'h4, 2'd0, 32'h00000066);
        do_read(BASE, 2'd1, rd);
        chk("R7 misses leave store", rd, 32'h00002222);
        do_read(28'h6FFFFC0, 2'd1, rd);
        chk("R7 miss reads zero", rd, 32'h0);
        do_read(BASE, 2'd3, rd);
        chk("R7 reserved size reads zero", rd, 32'h0);

        pin_dir = 16'h0000; pin_in = 16'h0F0F;
        idle(3);
        do_read(BASE, 2'd1, rd);
        chk("R3 input read", rd, 32'h00000F0F);
        chk("R5 inputs not driven", {pin_oe, pin_out}, 32'h0);
        pin_alt = 16'hFFFF;
        do_read(BASE, 2'd1, rd);
        chk("R3 input with alt", rd, 32'h00000F0F);
        pin_alt = 16'h0000;

        pin_in = 16'hF0F0;
        do_read(BASE, 2'd1, rd);
        chk("R3 latency edge 0", rd, 32'h00000F0F);
        do_read(BASE, 2'd1, rd);
        chk("R3 latency edge 1", rd, 32'h00000F0F);
        do_read(BASE, 2'd1, rd);
        chk("R3 latency edge 2", rd, 32'h0000F0F0);

        pin_dir = 16'hFFFF; pin_alt = 16'hFFFF;
        idle(1);
        do_read(BASE, 2'd1, rd);
        chk("R4 alt output reads store", rd, 32'h00002222);
        do_write(BASE, 2'd1, 32'h00001111);
        chk("R5 alt pins undriven", {pin_oe, pin_out}, 32'h0);
        do_read(BASE, 2'd1, rd);
        chk("R5 store updated under alt", rd, 32'h00001111);
        pin_alt = 16'h0000;
        idle(1);
        chk("R5 value appears on switch", {16'h0, pin_out}, 32'h1111);

        mrst_n = 1'b0; idle(2); mrst_n = 1'b1;
        standby = 1'b1; idle(2); standby = 1'b0;
        sleep = 1'b1; idle(2); sleep = 1'b0;
        idle(1);
        chk("R6 pin after mrst/lp", {16'h0, pin_out}, 32'h1111);
        do_read(BASE, 2'd1, rd);
        chk("R6 store kept", rd, 32'h00001111);

        pin_dir = 16'h0000; pin_in = 16'h1357;
        idle(3);
        standby = 1'b1;
        pin_in = 16'h2468;
        idle(4);
        do_read(BASE, 2'd1, rd);
        chk("R12 standby holds sync", rd, 32'h00001357);
        standby = 1'b0; sleep = 1'b1;
        idle(3);
        do_read(BASE, 2'd1, rd);
        chk("R12 sleep holds sync", rd, 32'h00001357);
        sleep = 1'b0;
        idle(3);
        do_read(BASE, 2'd1, rd);
        chk("R12 resume sampling", rd, 32'h00002468);

        for (int it = 0; it < 300; it++) begin
            logic [27:0] a;
            logic [1:0]  sz;
            logic [31:0] d;
            logic [31:0] exp_rd;
            int          kind;
            pin_dir = 16'($urandom); pin_alt = 16'($urandom); pin_in = 16'($urandom);
            idle(3);
            chk("R2 oe mode", {16'h0, pin_oe}, {16'h0, pin_dir & ~pin_alt});
            chk("R5 drive mode", {16'h0, pin_out}, {16'h0, exp_store & pin_dir & ~pin_alt});
            kind = int'($urandom % 10);
            sz   = 2'($urandom % 3);
            a    = {4'h5, 15'($urandom), 9'h1C0};
            if (sz == 2'd0) a[0] = 1'($urandom);
            if (kind == 0) a[27:24] = 4'h1 + 4'($urandom % 4);
            else if (kind == 1) a[8:1] = a[8:1] ^ (8'h1 << ($urandom % 8));
            else if (kind == 2) sz = 2'd3;
            d = $urandom;
            if ($urandom % 2) begin
                do_write(a, sz, d);
            end else begin
                exp_rd = fn_read(exp_store, pin_in, pin_dir, a, sz);
                do_read(a, sz, rd);
                chk("R7 R8 R9 R10 random read", rd, exp_rd);
            end
        end

        por_n = 1'b0;
        idle(1);
        por_n = 1'b1;
        exp_store = '0;
        pin_dir = 16'hFFFF;
        idle(1);
        do_read(BASE, 2'd1, rd);
        chk("R1 power-on clears again", rd, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule